// File: doc/BRIEF.md
# Peripheral Security Protection Gate

This block stands between one bus initiator and a bank of up to sixteen peripheral ports. Each request names its target port by index and carries an address, write data, a transfer size, a write flag, a secure flag and a user (unprivileged) flag. The gate weighs those attributes against per-port configuration levels. A request that passes is forwarded to the chosen port. A request that fails never reaches any port and is answered by the gate itself. A failed request also raises a sticky violation flag, which drives an interrupt line through an enable input.

Each port has two configuration levels. The ownership level marks the port as belonging to the non-secure world (1) or the secure world (0). The unprivileged-permit level allows user-mode requests (1) or refuses them (0). A build-time mask can exempt chosen ports from the ownership comparison. It never exempts them from the privilege check. One global level picks how refused requests end: with an error, or silently, with a read returning zero and a write dropped.

The gate decides in the request cycle. One register stage drives the downstream request and a second one returns the response. Every request, passed or refused, is answered two cycles after it was presented, provided the downstream port responds with zero wait states.

Top module: `psg_gate`

## Requirements
- R1: On a port whose exempt-mask bit is 0, a request passes the security check only when its secure flag differs from that port's ownership level (ownership 1 = non-secure port, 0 = secure port). Otherwise it is refused.
- R2: On a port whose bit in the parameter SEC_EXEMPT is 1, the secure flag is not checked at all.
- R3: A request with the user flag set is refused when the port's unprivileged-permit level is 0, whether or not the port is exempt.
- R4: A refused request asserts no downstream select bit, so a refused write never reaches a port.
- R5: When the error-select level is 1 in the request cycle, a refused request responds with error 1 and read data zero.
- R6: When the error-select level is 0 in the request cycle, a refused request responds with error 0 and read data zero.
- R7: A passed request asserts select bit number req_port_i, and only that bit, in the cycle after the request. In that cycle address, write data, size, write, secure and user match the request unchanged (size code 0/1/2/3 = 1/2/4/8 bytes).
- R8: Every request gets rsp_valid_o exactly two cycles after it was presented. For a passed request, read data and error equal dn_rdata_i and dn_err_i as sampled in the forwarding cycle. Requests may be issued back to back.
- R9: A refused request sets the sticky violation status at its clock edge unless irq_clr_i is 1 in that cycle. The status then stays set through later permitted requests.
- R10: irq_clr_i at 1 clears the violation status at the clock edge. The status stays clear after irq_clr_i falls, until the next refused request.
- R11: irq_o equals the violation status ANDed with irq_en_i, and it follows irq_en_i with no clock edge.
- R12: While rst_ni is low, the status is clear and no select bit, no response and no interrupt are driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present this cycle |
| req_port_i | input | IDX_W | Target port index |
| req_addr_i | input | 32 | Request address |
| req_wdata_i | input | 64 | Write data, little-endian lanes |
| req_size_i | input | 2 | Size code: 0=1, 1=2, 2=4, 3=8 bytes |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_secure_i | input | 1 | Secure-world request |
| req_user_i | input | 1 | Unprivileged request |
| rsp_valid_o | output | 1 | Response present |
| rsp_rdata_o | output | 64 | Response read data |
| rsp_err_o | output | 1 | Response error |
| dn_sel_o | output | NUM_PORTS | One-hot downstream select |
| dn_addr_o | output | 32 | Forwarded address |
| dn_wdata_o | output | 64 | Forwarded write data |
| dn_size_o | output | 2 | Forwarded size code |
| dn_write_o | output | 1 | Forwarded write flag |
| dn_secure_o | output | 1 | Forwarded secure flag |
| dn_user_o | output | 1 | Forwarded user flag |
| dn_rdata_i | input | 64 | Downstream read data, same cycle as select |
| dn_err_i | input | 1 | Downstream error, same cycle as select |
| cfg_ns_own_i | input | NUM_PORTS | Per-port ownership: 1 = non-secure |
| cfg_unpriv_i | input | NUM_PORTS | Per-port permit for unprivileged requests |
| blk_err_sel_i | input | 1 | Refused requests: 1 = error, 0 = silent |
| irq_en_i | input | 1 | Interrupt enable |
| irq_clr_i | input | 1 | Violation status clear |
| irq_o | output | 1 | Violation interrupt |

## Verification
A refused request and a held clear input can land on the same clock edge. The set and the clear then compete for the violation status, and the clear must win. The bench raises irq_clr_i in the cycle it presents a refused request. After the edge it expects irq_o low with the enable high. It checks again once the clear has dropped, to confirm that nothing was latched. A second collision applies clear and enable changes around a status that is already set. This separates the combinational enable path from the registered clear.

// File: rtl/psg_pkg.sv
package psg_pkg;
  parameter int unsigned ADDR_W = 32;
  parameter int unsigned DATA_W = 64;

  typedef enum logic [1:0] {
    SZ_B1 = 2'd0,
    SZ_B2 = 2'd1,
    SZ_B4 = 2'd2,
    SZ_B8 = 2'd3
  } xfer_size_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata;
    xfer_size_e        size;
    logic              write;
    logic              secure;
    logic              user;
  } xfer_req_t;
endpackage

// File: rtl/psg_check.sv
module psg_check #(
  parameter int unsigned NUM_PORTS  = 16,
  parameter logic [NUM_PORTS-1:0] SEC_EXEMPT = '0,
  localparam int unsigned IDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic [IDX_W-1:0]     port_i,
  input  logic                 secure_i,
  input  logic                 user_i,
  input  logic [NUM_PORTS-1:0] ns_own_i,
  input  logic [NUM_PORTS-1:0] unpriv_i,
  output logic                 pass_o
);
  logic [NUM_PORTS-1:0] port_ok;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic sec_ok, priv_ok;
    if (SEC_EXEMPT[p]) begin : g_exempt
      assign sec_ok = 1'b1;
    end else begin : g_checked
      assign sec_ok = (secure_i != ns_own_i[p]);
    end
    assign priv_ok    = !user_i || unpriv_i[p];
    assign port_ok[p] = sec_ok && priv_ok;
  end

  logic in_range;
  assign in_range = (32'(port_i) < NUM_PORTS);
  assign pass_o   = in_range && port_ok[port_i];
endmodule

// File: rtl/psg_irq.sv
module psg_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic viol_i,
  input  logic irq_en_i,
  input  logic irq_clr_i,
  output logic irq_o
);
  logic status_q;

  // clear wins over a same-cycle violation
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        status_q <= 1'b0;
    else if (irq_clr_i) status_q <= 1'b0;
    else if (viol_i)    status_q <= 1'b1;
  end

  assign irq_o = status_q && irq_en_i;

  // R9
  set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_i && !irq_clr_i |=> status_q);
  // R9
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_q && !irq_clr_i |=> status_q);
  // R10
  clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_clr_i |=> !irq_o);
endmodule

// File: rtl/psg_stage.sv
module psg_stage
  import psg_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 16,
  localparam int unsigned IDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_valid_i,
  input  logic                 pass_i,
  input  logic [IDX_W-1:0]     port_i,
  input  xfer_req_t            req_i,
  input  logic                 blk_err_sel_i,
  output logic [NUM_PORTS-1:0] dn_sel_o,
  output xfer_req_t            dn_req_o,
  input  logic [DATA_W-1:0]    dn_rdata_i,
  input  logic                 dn_err_i,
  output logic                 rsp_valid_o,
  output logic [DATA_W-1:0]    rsp_rdata_o,
  output logic                 rsp_err_o
);
  logic             fwd_q, blk_q, blk_err_q;
  logic [IDX_W-1:0] port_q;
  xfer_req_t        req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fwd_q     <= 1'b0;
      blk_q     <= 1'b0;
      blk_err_q <= 1'b0;
      port_q    <= '0;
      req_q     <= '0;
    end else begin
      fwd_q     <= req_valid_i && pass_i;
      blk_q     <= req_valid_i && !pass_i;
      blk_err_q <= blk_err_sel_i;
      if (req_valid_i && pass_i) begin
        port_q <= port_i;
        req_q  <= req_i;
      end
    end
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_sel
    assign dn_sel_o[p] = fwd_q && (32'(port_q) == p);
  end
  assign dn_req_o = req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
      rsp_err_o   <= 1'b0;
    end else begin
      rsp_valid_o <= fwd_q || blk_q;
      rsp_rdata_o <= fwd_q ? dn_rdata_i : '0;
      rsp_err_o   <= fwd_q ? dn_err_i : (blk_q && blk_err_q);
    end
  end

  // R4
  blk_fwd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|dn_sel_o) |-> $past(req_valid_i && pass_i));
  // R7
  sel_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(dn_sel_o));
  // R8
  rsp_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |-> ##2 rsp_valid_o);
  // R6
  blk_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && $past(blk_q) |-> rsp_rdata_o == '0);
endmodule

// File: rtl/psg_gate.sv
module psg_gate
  import psg_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 16,
  parameter logic [NUM_PORTS-1:0] SEC_EXEMPT = '0,
  localparam int unsigned IDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_valid_i,
  input  logic [IDX_W-1:0]     req_port_i,
  input  logic [ADDR_W-1:0]    req_addr_i,
  input  logic [DATA_W-1:0]    req_wdata_i,
  input  logic [1:0]           req_size_i,
  input  logic                 req_write_i,
  input  logic                 req_secure_i,
  input  logic                 req_user_i,
  output logic                 rsp_valid_o,
  output logic [DATA_W-1:0]    rsp_rdata_o,
  output logic                 rsp_err_o,
  output logic [NUM_PORTS-1:0] dn_sel_o,
  output logic [ADDR_W-1:0]    dn_addr_o,
  output logic [DATA_W-1:0]    dn_wdata_o,
  output logic [1:0]           dn_size_o,
  output logic                 dn_write_o,
  output logic                 dn_secure_o,
  output logic                 dn_user_o,
  input  logic [DATA_W-1:0]    dn_rdata_i,
  input  logic                 dn_err_i,
  input  logic [NUM_PORTS-1:0] cfg_ns_own_i,
  input  logic [NUM_PORTS-1:0] cfg_unpriv_i,
  input  logic                 blk_err_sel_i,
  input  logic                 irq_en_i,
  input  logic                 irq_clr_i,
  output logic                 irq_o
);
  logic      pass;
  xfer_req_t req, dn_req;

  assign req = '{addr: req_addr_i, wdata: req_wdata_i, size: xfer_size_e'(req_size_i),
                 write: req_write_i, secure: req_secure_i, user: req_user_i};

  psg_check #(.NUM_PORTS(NUM_PORTS), .SEC_EXEMPT(SEC_EXEMPT)) u_check (
    .port_i   (req_port_i),
    .secure_i (req_secure_i),
    .user_i   (req_user_i),
    .ns_own_i (cfg_ns_own_i),
    .unpriv_i (cfg_unpriv_i),
    .pass_o   (pass)
  );

  psg_stage #(.NUM_PORTS(NUM_PORTS)) u_stage (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .req_valid_i   (req_valid_i),
    .pass_i        (pass),
    .port_i        (req_port_i),
    .req_i         (req),
    .blk_err_sel_i (blk_err_sel_i),
    .dn_sel_o      (dn_sel_o),
    .dn_req_o      (dn_req),
    .dn_rdata_i    (dn_rdata_i),
    .dn_err_i      (dn_err_i),
    .rsp_valid_o   (rsp_valid_o),
    .rsp_rdata_o   (rsp_rdata_o),
    .rsp_err_o     (rsp_err_o)
  );

  assign dn_addr_o   = dn_req.addr;
  assign dn_wdata_o  = dn_req.wdata;
  assign dn_size_o   = dn_req.size;
  assign dn_write_o  = dn_req.write;
  assign dn_secure_o = dn_req.secure;
  assign dn_user_o   = dn_req.user;

  psg_irq u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .viol_i    (req_valid_i && !pass),
    .irq_en_i  (irq_en_i),
    .irq_clr_i (irq_clr_i),
    .irq_o     (irq_o)
  );

  // R3
  user_blk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_user_i && !cfg_unpriv_i[req_port_i] |=> dn_sel_o == '0);
endmodule

// File: tb/psg_gate_test.sv
`timescale 1ns/1ps
module psg_gate_test;
  localparam int unsigned NP = 16;
  localparam logic [NP-1:0] EXEMPT = 16'h8001;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          req_valid, req_write, req_secure, req_user;
  logic [3:0]    req_port;
  logic [31:0]   req_addr;
  logic [63:0]   req_wdata;
  logic [1:0]    req_size;
  logic          rsp_valid, rsp_err;
  logic [63:0]   rsp_rdata;
  logic [NP-1:0] dn_sel;
  logic [31:0]   dn_addr;
  logic [63:0]   dn_wdata, dn_rdata;
  logic [1:0]    dn_size;
  logic          dn_write, dn_secure, dn_user, dn_err;
  logic [NP-1:0] cfg_ns, cfg_up;
  logic          err_sel, irq_en, irq_clr, irq;

  // zero-wait downstream model
  assign dn_rdata = {dn_addr, ~dn_addr};
  assign dn_err   = dn_addr[31];

  psg_gate #(.NUM_PORTS(NP), .SEC_EXEMPT(EXEMPT)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_port_i(req_port), .req_addr_i(req_addr),
    .req_wdata_i(req_wdata), .req_size_i(req_size), .req_write_i(req_write),
    .req_secure_i(req_secure), .req_user_i(req_user),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .rsp_err_o(rsp_err),
    .dn_sel_o(dn_sel), .dn_addr_o(dn_addr), .dn_wdata_o(dn_wdata), .dn_size_o(dn_size),
    .dn_write_o(dn_write), .dn_secure_o(dn_secure), .dn_user_o(dn_user),
    .dn_rdata_i(dn_rdata), .dn_err_i(dn_err),
    .cfg_ns_own_i(cfg_ns), .cfg_unpriv_i(cfg_up), .blk_err_sel_i(err_sel),
    .irq_en_i(irq_en), .irq_clr_i(irq_clr), .irq_o(irq)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  typedef struct packed {
    logic [3:0]  port;
    logic        sec, usr, own, upr, esel, wr;
    logic [1:0]  size;
    logic [31:0] addr;
    logic        exp_fwd;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{4'd3,  1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd2, 32'h0000_1000, 1'b1}, // R1 pass
    '{4'd3,  1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 2'd2, 32'h0000_1004, 1'b0}, // R1 R5
    '{4'd4,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 32'h0000_2001, 1'b0}, // R1 R6
    '{4'd4,  1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd1, 32'h0000_2002, 1'b1}, // R1 pass
    '{4'd0,  1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 2'd3, 32'h0000_0008, 1'b1}, // R2
    '{4'd15, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 2'd3, 32'h0000_F010, 1'b1}, // R2 write
    '{4'd5,  1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 2'd2, 32'h0000_5000, 1'b0}, // R3
    '{4'd0,  1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 2'd2, 32'h0000_0020, 1'b0}, // R3 exempt
    '{4'd7,  1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 2'd1, 32'h0000_7002, 1'b1}, // R3 permit
    '{4'd9,  1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd2, 32'h8000_0040, 1'b1}, // R8 err pass-through
    '{4'd12, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 2'd3, 32'h0000_C000, 1'b0}, // R4 R6 write
    '{4'd2,  1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0, 32'h0000_2003, 1'b1}  // R7 byte
  };

  task automatic drive(input vec_t v);
    req_port = v.port; req_secure = v.sec; req_user = v.usr; req_write = v.wr;
    req_size = v.size; req_addr = v.addr; req_wdata = {v.addr, 32'hA5A5_0000 | v.addr};
    cfg_ns = {NP{v.own}}; cfg_up = {NP{v.upr}}; err_sel = v.esel;
    req_valid = 1'b1;
  endtask

  task automatic pulse_clr();
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %h expected %h", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    req_valid = 0; req_port = 0; req_addr = 0; req_wdata = 0; req_size = 0;
    req_write = 0; req_secure = 0; req_user = 0; cfg_ns = 0; cfg_up = 0;
    err_sel = 0; irq_en = 1; irq_clr = 0;
    repeat (3) @(negedge clk);
    // R12 reset state
    check(irq == 1'b0 && dn_sel == '0 && rsp_valid == 1'b0, "R12 reset idle",
          {irq, dn_sel, rsp_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    foreach (VECS[i]) begin
      vec_t v;
      logic [63:0] exp_rd;
      logic exp_err;
      v = VECS[i];
      drive(v);
      @(negedge clk);
      req_valid = 1'b0;
      // R4 R7: select and forwarded fields, one cycle after request
      check(dn_sel == (v.exp_fwd ? (NP'(1) << v.port) : '0), $sformatf("R4/R7 sel vec%0d", i),
            64'(dn_sel), 64'(v.exp_fwd ? (NP'(1) << v.port) : '0));
      if (v.exp_fwd)
        check(dn_addr == v.addr && dn_size == v.size && dn_write == v.wr &&
              dn_secure == v.sec && dn_user == v.usr && dn_wdata == {v.addr, 32'hA5A5_0000 | v.addr},
              $sformatf("R7 fields vec%0d", i), {dn_addr, 30'd0, dn_size}, {v.addr, 30'd0, v.size});
      // R9 status from a refused request
      check(irq == !v.exp_fwd, $sformatf("R9 irq vec%0d", i), 64'(irq), 64'(!v.exp_fwd));
      @(negedge clk);
      exp_rd  = v.exp_fwd ? {v.addr, ~v.addr} : 64'd0;
      exp_err = v.exp_fwd ? v.addr[31] : v.esel;
      check(rsp_valid && rsp_rdata == exp_rd && rsp_err == exp_err,
            $sformatf("R5/R6/R8 rsp vec%0d", i), {rsp_rdata[62:0], rsp_err}, {exp_rd[62:0], exp_err});
      pulse_clr();
    end

    // R10: clear empties the status, stays clear afterwards
    drive(VECS[1]); @(negedge clk); req_valid = 1'b0;
    check(irq == 1'b1, "R9 set before clear", 64'(irq), 1);
    // R9 sticky across a permitted request
    drive(VECS[0]); @(negedge clk); req_valid = 1'b0;
    repeat (2) @(negedge clk);
    check(irq == 1'b1, "R9 sticky", 64'(irq), 1);
    // R11 enable gates without a clock edge
    irq_en = 1'b0; #1;
    check(irq == 1'b0, "R11 enable low", 64'(irq), 0);
    irq_en = 1'b1; #1;
    check(irq == 1'b1, "R11 enable high", 64'(irq), 1);
    pulse_clr();
    check(irq == 1'b0, "R10 cleared", 64'(irq), 0);
    @(negedge clk);
    check(irq == 1'b0, "R10 stays clear", 64'(irq), 0);

    // R9 collision: refused request while clear is held
    drive(VECS[2]); irq_clr = 1'b1;
    @(negedge clk); req_valid = 1'b0;
    check(irq == 1'b0, "R9 clear wins", 64'(irq), 0);
    irq_clr = 1'b0;
    @(negedge clk);
    check(irq == 1'b0, "R9 nothing latched", 64'(irq), 0);

    // R8 back to back: pass then refuse in consecutive cycles
    drive(VECS[0]);
    @(negedge clk); drive(VECS[1]);
    @(negedge clk); req_valid = 1'b0;
    check(rsp_valid && rsp_rdata == {VECS[0].addr, ~VECS[0].addr} && !rsp_err,
          "R8 b2b first", rsp_rdata, {VECS[0].addr, ~VECS[0].addr});
    @(negedge clk);
    check(rsp_valid && rsp_rdata == 64'd0 && rsp_err, "R8 b2b second", {rsp_rdata[62:0], rsp_err}, 1);
    @(negedge clk);
    check(!rsp_valid, "R8 no extra rsp", 64'(rsp_valid), 0);

    // R12 reset clears a set status
    check(irq == 1'b1, "R9 set before reset", 64'(irq), 1);
    rst_n = 1'b0; #1;
    check(irq == 1'b0 && dn_sel == '0 && !rsp_valid, "R12 reset clears", 64'(irq), 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule